// File: doc/BRIEF.md
# Shadowed Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel. While a data-enable strobe is active, it also gives the column and row of the current pixel. Software programs the following through a small register port:
- active width and height;
- the front porch, sync width and back porch for each axis;
- the output polarities;
- a frame-buffer base address, which is passed through to the pixel fetch logic.

Every programmable value is held twice. Software writes a pending copy and the counters use a live copy. The live copy is filled in two cases: when the controller starts from idle, and at the end of a frame while a self-clearing load request is pending. A register write in the middle of a frame therefore never tears the picture.

Clearing the run bit does not stop the timing at once. The current frame runs to its last pixel and the controller stops there, and the run bit reads as set until it has stopped. A status flag marks the start of vertical blanking and can drive an interrupt line. A soft-reset control holds the controller idle while it is being reconfigured.

Register map (word addresses):
- 0: control
- 1: active size
- 2: horizontal timing
- 3: vertical timing
- 4: blank status
- 5: interrupt enable
- 6: base address

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, irq, pix_x and pix_y are 0, and address 0 reads 0.
- R2: Horizontal timing follows these rules:
  - A running line lasts W+HFP+HSW+HBP clocks.
  - W is address 1 bits [ACT_W-1:0]. HFP, HSW and HBP are address 2 bits [7:0], [15:8] and [23:16].
  - de covers positions 0 to W-1, with pix_x equal to the position.
  - hsync covers positions W+HFP to W+HFP+HSW-1.
- R3: Vertical timing follows these rules:
  - A frame lasts H+VFP+VSW+VBP lines.
  - H is address 1 bits [DATA_W/2+ACT_W-1:DATA_W/2]. VFP, VSW and VBP use the address 3 layout of R2.
  - de is active only in lines 0 to H-1, with pix_y equal to the line.
  - vsync covers whole lines H+VFP to H+VFP+VSW-1, so it is never active together with de.
- R4: Control bits 3, 4 and 5 invert hsync, vsync and de respectively. Control bit 6 drives pclk_neg.
- R5: When control bit 0 is written to 1 while idle, the controller copies every pending value (timing, polarities, base address) into the live set. Pixel (0,0) appears in the second cycle after the write edge, and fb_base shows the pending base address at that point.
- R6: While running, writes to addresses 1, 2, 3 and 6 and to the polarity bits change only what is read back. The outputs keep the live values.
- R7: Writing 1 to control bit 1 sets a load request, which reads as 1 until the end of the frame. On the last pixel of the frame, the pending values become live and the bit clears.
- R8: When control bit 0 is cleared while running, the current frame completes. Bit 0 reads 1 through the frame's last pixel and 0 from the next cycle, and from then on the outputs are inactive.
- R9: Bit 0 at address 4 is set one cycle after the counters reach column 0 of line H. Writing 1 to it clears it. irq equals that bit ANDed with address 5 bit 0.
- R10: Control bit 2 is a soft reset. While it is set:
  - the controller goes idle after one cycle;
  - the enable bit, the load request and the status bit clear;
  - enable writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write word address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | DATA_W | Read data (combinational) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | ACT_W | Column during active, else 0 |
| pix_y | output | ACT_W | Row during active, else 0 |
| pclk_neg | output | 1 | Live falling-edge launch select |
| fb_base | output | DATA_W | Live frame-buffer base address |
| irq | output | 1 | Vertical blank interrupt |

## Verification
The assertions assume the following about the inputs:
- every active size, porch and sync width in use is at least 1;
- software asserts soft reset before changing timing that is already live without a load request;
- write strobes change only away from the rising edge.

The bench meets these conditions:
- it drives writes on the falling edge;
- every configuration in its table uses field values of 1 or more;
- it enters soft reset before loading each table entry.

Under these conditions the counters always wrap, so a frame end always occurs for the stop and commit checks to depend on.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_SIZE = 3'd1;
   localparam logic [ADDR_W-1:0] A_HTIM = 3'd2;
   localparam logic [ADDR_W-1:0] A_VTIM = 3'd3;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
   localparam logic [ADDR_W-1:0] A_IEN  = 3'd5;
   localparam logic [ADDR_W-1:0] A_BASE = 3'd6;

   localparam int B_RUN  = 0;
   localparam int B_LOAD = 1;
   localparam int B_SRST = 2;
   localparam int B_POL0 = 3;
   localparam int N_POL  = 4;

   localparam int SIG_HS = 0;
   localparam int SIG_VS = 1;
   localparam int SIG_DE = 2;
   localparam int N_SIG  = 3;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis #(
   parameter int ACT_W   = 16,
   parameter int PORCH_W = 8,
   parameter int CNT_W   = ACT_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold,
   input  logic               step,
   input  logic [ACT_W-1:0]   len_act,
   input  logic [PORCH_W-1:0] len_fp,
   input  logic [PORCH_W-1:0] len_sw,
   input  logic [PORCH_W-1:0] len_bp,
   output logic [CNT_W-1:0]   cnt,
   output logic               last,
   output logic               in_act,
   output logic               in_sync,
   output logic               fp_first,
   output logic               at_zero
);
   logic [CNT_W-1:0] e_act, e_fp, e_sw, e_bp;
   logic [CNT_W-1:0] sync_lo, sync_hi, total;

   assign e_act   = CNT_W'(len_act);
   assign e_fp    = CNT_W'(len_fp);
   assign e_sw    = CNT_W'(len_sw);
   assign e_bp    = CNT_W'(len_bp);
   assign sync_lo = e_act + e_fp;
   assign sync_hi = sync_lo + e_sw;
   assign total   = sync_hi + e_bp;

   assign last     = (cnt == total - CNT_W'(1));
   assign in_act   = (cnt < e_act);
   assign in_sync  = (cnt >= sync_lo) && (cnt < sync_hi);
   assign fp_first = (cnt == e_act);
   assign at_zero  = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= last ? '0 : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ACT_W   = 16,
   parameter int PORCH_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               frame_end,
   input  logic               vblank_hit,
   output logic               running,
   output logic               soft_rst,
   output logic [ACT_W-1:0]   act_hact,
   output logic [ACT_W-1:0]   act_vact,
   output logic [PORCH_W-1:0] act_hfp,
   output logic [PORCH_W-1:0] act_hsw,
   output logic [PORCH_W-1:0] act_hbp,
   output logic [PORCH_W-1:0] act_vfp,
   output logic [PORCH_W-1:0] act_vsw,
   output logic [PORCH_W-1:0] act_vbp,
   output logic [N_POL-1:0]   act_pol,
   output logic [DATA_W-1:0]  act_base,
   output logic               irq
);
   localparam int VOFF = DATA_W / 2;

   logic [ACT_W-1:0]   p_hact, p_vact;
   logic [PORCH_W-1:0] p_hfp, p_hsw, p_hbp, p_vfp, p_vsw, p_vbp;
   logic [N_POL-1:0]   p_pol;
   logic [DATA_W-1:0]  p_base;

   logic en_q, load_q, srst_q, run_q, stat_q, ien_q;
   logic wr_ctrl, wr_size, wr_htim, wr_vtim, wr_stat, wr_ien, wr_base;
   logic start, commit_frm, take, kill;
   logic unused_wr_bits;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_size = wr_en && (wr_addr == A_SIZE);
   assign wr_htim = wr_en && (wr_addr == A_HTIM);
   assign wr_vtim = wr_en && (wr_addr == A_VTIM);
   assign wr_stat = wr_en && (wr_addr == A_STAT);
   assign wr_ien  = wr_en && (wr_addr == A_IEN);
   assign wr_base = wr_en && (wr_addr == A_BASE);
   assign unused_wr_bits = ^wr_data;

   assign start      = en_q && !run_q && !srst_q;
   assign commit_frm = frame_end && load_q && en_q && !srst_q;
   assign take       = start || commit_frm;
   assign kill       = srst_q || (wr_ctrl && wr_data[B_SRST]);

   // Pending copies, written by software at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_hact <= '0; p_vact <= '0;
         p_hfp  <= '0; p_hsw  <= '0; p_hbp <= '0;
         p_vfp  <= '0; p_vsw  <= '0; p_vbp <= '0;
         p_pol  <= '0; p_base <= '0;
      end else begin
         if (wr_ctrl) p_pol <= wr_data[B_POL0 +: N_POL];
         if (wr_size) begin
            p_hact <= wr_data[0 +: ACT_W];
            p_vact <= wr_data[VOFF +: ACT_W];
         end
         if (wr_htim) begin
            p_hfp <= wr_data[0 +: PORCH_W];
            p_hsw <= wr_data[PORCH_W +: PORCH_W];
            p_hbp <= wr_data[2*PORCH_W +: PORCH_W];
         end
         if (wr_vtim) begin
            p_vfp <= wr_data[0 +: PORCH_W];
            p_vsw <= wr_data[PORCH_W +: PORCH_W];
            p_vbp <= wr_data[2*PORCH_W +: PORCH_W];
         end
         if (wr_base) p_base <= wr_data;
      end
   end

   // Live copies, filled at start or at a requested frame-end commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_hact <= '0; act_vact <= '0;
         act_hfp  <= '0; act_hsw  <= '0; act_hbp <= '0;
         act_vfp  <= '0; act_vsw  <= '0; act_vbp <= '0;
         act_pol  <= '0; act_base <= '0;
      end else if (take) begin
         act_hact <= p_hact; act_vact <= p_vact;
         act_hfp  <= p_hfp;  act_hsw  <= p_hsw;  act_hbp <= p_hbp;
         act_vfp  <= p_vfp;  act_vsw  <= p_vsw;  act_vbp <= p_vbp;
         act_pol  <= p_pol;  act_base <= p_base;
      end
   end

   // Control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         load_q <= 1'b0;
         srst_q <= 1'b0;
         run_q  <= 1'b0;
         stat_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (wr_ctrl) srst_q <= wr_data[B_SRST];

         if (kill)         en_q <= 1'b0;
         else if (wr_ctrl) en_q <= wr_data[B_RUN];

         if (kill)                             load_q <= 1'b0;
         else if (wr_ctrl && wr_data[B_LOAD])  load_q <= 1'b1;
         else if (take)                        load_q <= 1'b0;

         if (srst_q)         run_q <= 1'b0;
         else if (start)     run_q <= 1'b1;
         else if (frame_end) run_q <= en_q;

         if (srst_q)                     stat_q <= 1'b0;
         else if (vblank_hit)            stat_q <= 1'b1;
         else if (wr_stat && wr_data[0]) stat_q <= 1'b0;

         if (wr_ien) ien_q <= wr_data[0];
      end
   end

   assign running  = run_q;
   assign soft_rst = srst_q;
   assign irq      = stat_q && ien_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[B_RUN]            = en_q || run_q;
            rd_data[B_LOAD]           = load_q;
            rd_data[B_SRST]           = srst_q;
            rd_data[B_POL0 +: N_POL]  = p_pol;
         end
         A_SIZE: begin
            rd_data[0 +: ACT_W]    = p_hact;
            rd_data[VOFF +: ACT_W] = p_vact;
         end
         A_HTIM: rd_data[3*PORCH_W-1:0] = {p_hbp, p_hsw, p_hfp};
         A_VTIM: rd_data[3*PORCH_W-1:0] = {p_vbp, p_vsw, p_vfp};
         A_STAT: rd_data[0] = stat_q;
         A_IEN:  rd_data[0] = ien_q;
         A_BASE: rd_data    = p_base;
         default: rd_data   = '0;
      endcase
   end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ACT_W   = 16,
   parameter int PORCH_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [ACT_W-1:0]  pix_x,
   output logic [ACT_W-1:0]  pix_y,
   output logic              pclk_neg,
   output logic [DATA_W-1:0] fb_base,
   output logic              irq
);
   localparam int CNT_W = ((ACT_W > PORCH_W) ? ACT_W : PORCH_W) + 2;

   if (ACT_W > DATA_W / 2) begin : g_bad_size
      $error("ACT_W must fit in half of DATA_W");
   end
   if (3 * PORCH_W > DATA_W) begin : g_bad_porch
      $error("three porch fields must fit in DATA_W");
   end
   if (PORCH_W < 1 || ACT_W < 1) begin : g_bad_min
      $error("field widths must be at least 1");
   end
   if (B_POL0 + N_POL > DATA_W) begin : g_bad_ctrl
      $error("control bits exceed DATA_W");
   end

   logic               running, soft_rst, frame_end, vblank_hit;
   logic [ACT_W-1:0]   act_hact, act_vact;
   logic [PORCH_W-1:0] act_hfp, act_hsw, act_hbp, act_vfp, act_vsw, act_vbp;
   logic [N_POL-1:0]   act_pol;
   logic [CNT_W-1:0]   h_cnt, v_cnt;
   logic               h_last, v_last, h_act, v_act, h_sync, v_sync;
   logic               h_fpf, v_fpf, h_zero, v_zero;
   logic               hold;
   logic [N_SIG-1:0]   raw, pol_out;
   logic               unused_cnt_bits;

   dtg_regs #(.DATA_W(DATA_W), .ACT_W(ACT_W), .PORCH_W(PORCH_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we), .wr_addr(reg_addr), .wr_data(reg_wdata),
      .rd_addr(reg_raddr), .rd_data(reg_rdata),
      .frame_end(frame_end), .vblank_hit(vblank_hit),
      .running(running), .soft_rst(soft_rst),
      .act_hact(act_hact), .act_vact(act_vact),
      .act_hfp(act_hfp), .act_hsw(act_hsw), .act_hbp(act_hbp),
      .act_vfp(act_vfp), .act_vsw(act_vsw), .act_vbp(act_vbp),
      .act_pol(act_pol), .act_base(fb_base), .irq(irq)
   );

   assign hold = soft_rst || !running;

   dtg_axis #(.ACT_W(ACT_W), .PORCH_W(PORCH_W), .CNT_W(CNT_W)) u_haxis (
      .clk(clk), .rst_n(rst_n), .hold(hold), .step(running),
      .len_act(act_hact), .len_fp(act_hfp), .len_sw(act_hsw), .len_bp(act_hbp),
      .cnt(h_cnt), .last(h_last), .in_act(h_act), .in_sync(h_sync),
      .fp_first(h_fpf), .at_zero(h_zero)
   );

   dtg_axis #(.ACT_W(ACT_W), .PORCH_W(PORCH_W), .CNT_W(CNT_W)) u_vaxis (
      .clk(clk), .rst_n(rst_n), .hold(hold), .step(running && h_last),
      .len_act(act_vact), .len_fp(act_vfp), .len_sw(act_vsw), .len_bp(act_vbp),
      .cnt(v_cnt), .last(v_last), .in_act(v_act), .in_sync(v_sync),
      .fp_first(v_fpf), .at_zero(v_zero)
   );

   assign unused_cnt_bits = ^{h_cnt, v_cnt, h_fpf, v_zero};

   assign frame_end  = running && h_last && v_last;
   assign vblank_hit = running && v_fpf && h_zero;

   assign raw[SIG_HS] = running && h_sync;
   assign raw[SIG_VS] = running && v_sync;
   assign raw[SIG_DE] = running && h_act && v_act;

   for (genvar gi = 0; gi < N_SIG; gi++) begin : g_pol
      assign pol_out[gi] = raw[gi] ^ act_pol[gi];
   end

   assign hsync    = pol_out[SIG_HS];
   assign vsync    = pol_out[SIG_VS];
   assign de       = pol_out[SIG_DE];
   assign pclk_neg = act_pol[N_POL-1];
   assign pix_x    = raw[SIG_DE] ? h_cnt[ACT_W-1:0] : '0;
   assign pix_y    = raw[SIG_DE] ? v_cnt[ACT_W-1:0] : '0;
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
   parameter int DATA_W = 32,
   parameter int ACT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic              srst_q,
   input logic              frame_end,
   input logic              load_q,
   input logic              take,
   input logic              kill,
   input logic              stat_q,
   input logic              vblank_hit,
   input logic              de_raw,
   input logic              vs_raw,
   input logic [ACT_W-1:0]  act_hact,
   input logic [DATA_W-1:0] act_base
);
   // R8
   stop_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && $past(run_q) && !$past(srst_q)) |-> $past(frame_end));

   // R7
   load_clears_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(load_q) |-> $past(take || kill));

   // R6
   live_set_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!take) |-> ($stable(act_hact) && $stable(act_base)));

   // R9
   status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q) |-> $past(vblank_hit));

   // R3
   de_outside_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(de_raw && vs_raw));

   // R10
   soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> !run_q);
endmodule

bind disp_timing_gen dtg_chk #(.DATA_W(DATA_W), .ACT_W(ACT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(running), .srst_q(soft_rst),
   .frame_end(frame_end), .load_q(u_regs.load_q), .take(u_regs.take),
   .kill(u_regs.kill), .stat_q(u_regs.stat_q), .vblank_hit(vblank_hit),
   .de_raw(raw[SIG_DE]), .vs_raw(raw[SIG_VS]),
   .act_hact(act_hact), .act_base(fb_base)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
   localparam int DATA_W = 32;
   localparam int ACT_W  = 16;
   localparam int NCFG   = 4;
   // hact hfp hsw hbp vact vfp vsw vbp pol
   localparam int CFG [NCFG][9] = '{
      '{4, 1, 2, 1, 3, 1, 1, 2, 0},
      '{5, 1, 1, 1, 2, 2, 1, 1, 15},
      '{3, 2, 3, 2, 4, 1, 2, 1, 5},
      '{1, 1, 1, 1, 1, 1, 1, 1, 10}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [2:0]        reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [2:0]        reg_raddr = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              hsync, vsync, de, pclk_neg, irq;
   logic [ACT_W-1:0]  pix_x, pix_y;
   logic [DATA_W-1:0] fb_base;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   disp_timing_gen #(.DATA_W(DATA_W), .ACT_W(ACT_W), .PORCH_W(8)) i_disp_timing_gen (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .pclk_neg(pclk_neg), .fb_base(fb_base), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_fs();
      do @(negedge clk); while (!(de === 1'b1 && pix_x == '0 && pix_y == '0));
   endtask

   task automatic program_cfg(input int c);
      wr(3'd0, 32'h4);
      wr(3'd0, 32'h0);
      wr(3'd1, (CFG[c][4] << 16) | CFG[c][0]);
      wr(3'd2, CFG[c][1] | (CFG[c][2] << 8) | (CFG[c][3] << 16));
      wr(3'd3, CFG[c][5] | (CFG[c][6] << 8) | (CFG[c][7] << 16));
      wr(3'd6, 32'h1000 + c);
      wr(3'd0, 32'h1 | (CFG[c][8] << 3));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d);
      check("R1 ctrl", 64'(d), 64'd0);
      check("R1 outputs", 64'({hsync, vsync, de, irq, pix_x, pix_y}), 64'd0);

      // Table of configurations, each checked over a full frame plus wrap
      for (int c = 0; c < NCFG; c++) begin
         int ht, vt, tot;
         program_cfg(c);
         @(negedge clk);
         ht  = CFG[c][0] + CFG[c][1] + CFG[c][2] + CFG[c][3];
         vt  = CFG[c][4] + CFG[c][5] + CFG[c][6] + CFG[c][7];
         tot = ht * vt;
         // R5 pending base taken at start
         check("R5 base at start", 64'(fb_base), 64'(32'h1000 + c));
         // R4 falling-edge launch select
         check("R4 pclk_neg", 64'(pclk_neg), 64'((CFG[c][8] >> 3) & 1));
         for (int k = 0; k <= tot; k++) begin
            int h, v;
            logic e_hs, e_vs, e_de;
            logic [15:0] e_px, e_py;
            h = k % ht;
            v = (k / ht) % vt;
            e_de = (h < CFG[c][0]) && (v < CFG[c][4]);
            e_hs = (h >= CFG[c][0] + CFG[c][1]) && (h < CFG[c][0] + CFG[c][1] + CFG[c][2]);
            e_vs = (v >= CFG[c][4] + CFG[c][5]) && (v < CFG[c][4] + CFG[c][5] + CFG[c][6]);
            e_px = e_de ? 16'(h) : 16'd0;
            e_py = e_de ? 16'(v) : 16'd0;
            // R2 R3 R4 timing and polarity
            check("R2/R3/R4 frame",
                  64'({hsync, vsync, de, pix_x, pix_y}),
                  64'({e_hs ^ CFG[c][8][0], e_vs ^ CFG[c][8][1], e_de ^ CFG[c][8][2], e_px, e_py}));
            @(negedge clk);
         end
      end

      // R6 writes while running are not live without a load request
      program_cfg(0);
      wait_fs();
      wr(3'd1, (3 << 16) | 6);
      wr(3'd6, 32'h55);
      rd(3'd1, d);
      check("R6 pending readback", 64'(d), 64'((3 << 16) | 6));
      wait_fs();
      n = 0;
      while (de === 1'b1) begin n++; @(negedge clk); end
      check("R6 width unchanged", 64'(n), 64'd4);
      check("R6 base unchanged", 64'(fb_base), 64'h1000);

      // R7 load request commits at frame end and self-clears
      wr(3'd0, 32'h3);
      rd(3'd0, d);
      check("R7 load pending", 64'(d), 64'h3);
      wait_fs();
      n = 0;
      while (de === 1'b1) begin n++; @(negedge clk); end
      check("R7 width committed", 64'(n), 64'd6);
      rd(3'd0, d);
      check("R7 load cleared", 64'(d), 64'h1);
      check("R7 base committed", 64'(fb_base), 64'h55);

      // R9 vertical blank status and interrupt (htot 10, vact 3)
      wr(3'd5, 32'h1);
      wait_fs();
      wr(3'd4, 32'h1);
      repeat (28) @(negedge clk);
      check("R9 irq before blank", 64'(irq), 64'd0);
      @(negedge clk);
      check("R9 irq at blank", 64'(irq), 64'd1);
      rd(3'd4, d);
      check("R9 status set", 64'(d), 64'd1);
      wr(3'd5, 32'h0);
      check("R9 irq masked", 64'(irq), 64'd0);
      rd(3'd4, d);
      check("R9 status kept", 64'(d), 64'd1);
      wr(3'd4, 32'h1);
      rd(3'd4, d);
      check("R9 w1c", 64'(d), 64'd0);

      // R8 graceful stop at frame end (frame of 70 cycles)
      wait_fs();
      wr(3'd0, 32'h0);
      rd(3'd0, d);
      check("R8 still running", 64'(d), 64'h1);
      repeat (67) @(negedge clk);
      rd(3'd0, d);
      check("R8 last pixel running", 64'(d), 64'h1);
      @(negedge clk);
      rd(3'd0, d);
      check("R8 stopped", 64'(d), 64'h0);
      check("R8 outputs idle", 64'({hsync, vsync, de}), 64'd0);
      repeat (20) @(negedge clk);
      check("R8 stays idle", 64'(de), 64'd0);

      // R10 soft reset
      wr(3'd0, 32'h1);
      repeat (5) @(negedge clk);
      wr(3'd0, 32'h3);
      wr(3'd0, 32'h5);
      @(negedge clk);
      check("R10 de idle", 64'(de), 64'd0);
      rd(3'd0, d);
      check("R10 ctrl cleared", 64'(d), 64'h4);
      rd(3'd4, d);
      check("R10 status cleared", 64'(d), 64'd0);
      wr(3'd0, 32'h5);
      repeat (3) @(negedge clk);
      rd(3'd0, d);
      check("R10 enable ignored", 64'(d), 64'h4);
      check("R10 still idle", 64'(de), 64'd0);
      wr(3'd0, 32'h0);
      rd(3'd0, d);
      check("R10 released", 64'(d), 64'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule